// File: doc/BRIEF.md
# Crystal Oscillator Power-State Controller

This block is the device-side model of a radio transceiver's global power states. It tracks three states: IDLE, oscillator-off (XOFF) and SLEEP. It decides when the crystal oscillator is enabled, and it produces the active-low chip-ready flag that the serial output pin shows while the device is selected. A counter stands in for the oscillator's start-up. Each time the oscillator is enabled, the counter starts from zero and counts up to a programmable settling delay. The chip is ready once the counter reaches that delay.

The inputs are the following:
- decoded one-cycle command strobes for oscillator-off, power-down and reset;
- the active-low chip select;
- a force-on configuration bit;
- the settling delay.

The two low-power states can only be entered from IDLE. Once the device is in one of them, the oscillator stops when the chip select is released. Selecting the chip again brings the oscillator back up and returns the state to IDLE. With the force-on bit set, the oscillator never stops, although the state transitions still follow the chip select.

Top module: `xosc_power_ctrl`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `state` is IDLE (encoding 0) and `xoscEn` is 1. After release, `soReadyN` stays 1 until `startDelay` rising edges have been counted.
- R2: `soReadyN` goes low exactly `startDelay` rising edges after the oscillator becomes enabled, and at once when `startDelay` is 0. It is 1 whenever `xoscEn` is 0.
- R3: In IDLE, `strobeXoff` moves `state` to XOFF (encoding 1) at the next edge, and `strobePwrDown` moves it to SLEEP (encoding 2). If both strobes arrive together, XOFF wins. Encoding 3 never appears.
- R4: Outside IDLE, `strobeXoff` and `strobePwrDown` leave `state` unchanged.
- R5: In XOFF or SLEEP with `forceOn` at 0, a rising edge that samples `csN` high turns `xoscEn` off after that edge, and `soReadyN` goes to 1.
- R6: In XOFF or SLEEP after such a deselection, the first edge that samples `csN` low returns `state` to IDLE with `xoscEn` at 1. Settling then restarts from zero.
- R7: While `forceOn` is 1, `xoscEn` is 1 in every state, and a completed settling is not lost when the chip is deselected or reselected.
- R8: `strobeReset` returns `state` to IDLE from any state at the next edge, with `xoscEn` at 1 and settling restarted from zero. It takes priority over the other strobes.
- R9: `soOe` is 1 exactly while `csN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| csN | input | 1 | Chip select, active low |
| strobeXoff | input | 1 | Decoded oscillator-off command, one cycle |
| strobePwrDown | input | 1 | Decoded power-down command, one cycle |
| strobeReset | input | 1 | Decoded reset command, one cycle |
| forceOn | input | 1 | Keep the oscillator enabled in all states |
| startDelay | input | DW | Settling delay in clock cycles |
| state | output | 2 | 0 IDLE, 1 XOFF, 2 SLEEP |
| xoscEn | output | 1 | Oscillator enable |
| soReadyN | output | 1 | Chip-ready flag for the serial output, active low |
| soOe | output | 1 | Serial output drive enable |

## Verification
The bench sweeps every settling delay from 0 to 5 with the force-on bit both clear and set. For each setting it samples the ready flag in every cycle after reset, after a wake-up and after a reset strobe. An off-by-one in the counter or in the wake path shows up as the flag falling a cycle early or late, and a zero delay that stalls shows up as a flag that never falls.

It also issues strobes in the low-power states, which a design that ignored the IDLE-only rule would obey. It checks that a forced-on oscillator keeps its ready flag across a deselection, where a design that cleared the counter anyway would report not-ready. Finally, it sends simultaneous strobes that expose a wrong priority order.

// File: rtl/xosc_pwr_pkg.sv
package xosc_pwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XOFF  = 2'd1,
    ST_SLEEP = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic clearCnt;
    logic oscEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/xosc_power_fsm.sv
module xosc_power_fsm
  import xosc_pwr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csN,
  input  logic         strobeXoff,
  input  logic         strobePwrDown,
  input  logic         strobeReset,
  input  logic         forceOn,
  output pwrState_t    curState,
  output ctrlStrobes_t ctrl
);
  pwrState_t nextState;
  logic deselected, nextDeselected;
  logic lowPower;

  assign lowPower = (curState == ST_XOFF) || (curState == ST_SLEEP);

  always_comb begin
    nextState      = curState;
    nextDeselected = deselected;
    if (strobeReset) begin
      nextState      = ST_IDLE;
      nextDeselected = 1'b0;
    end else begin
      unique case (curState)
        ST_IDLE: begin
          nextDeselected = 1'b0;
          if (strobeXoff)         nextState = ST_XOFF;
          else if (strobePwrDown) nextState = ST_SLEEP;
        end
        ST_XOFF, ST_SLEEP: begin
          if (csN) begin
            nextDeselected = 1'b1;
          end else if (deselected) begin
            nextState      = ST_IDLE;
            nextDeselected = 1'b0;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState   <= ST_IDLE;
      deselected <= 1'b0;
    end else begin
      curState   <= nextState;
      deselected <= nextDeselected;
    end
  end

  assign ctrl.oscEn    = forceOn || !(lowPower && deselected);
  assign ctrl.clearCnt = strobeReset;
endmodule

// File: rtl/xosc_settle_dp.sv
module xosc_settle_dp
  import xosc_pwr_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobes_t  ctrl,
  input  logic [DW-1:0] startDelay,
  output logic          ready
);
  logic [DW-1:0] settleCnt;
  logic          reached;

  assign reached = (settleCnt >= startDelay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settleCnt <= '0;
    end else if (ctrl.clearCnt || !ctrl.oscEn) begin
      settleCnt <= '0;
    end else if (!reached) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign ready = ctrl.oscEn && reached;
endmodule

// File: rtl/xosc_power_ctrl.sv
module xosc_power_ctrl
  import xosc_pwr_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csN,
  input  logic          strobeXoff,
  input  logic          strobePwrDown,
  input  logic          strobeReset,
  input  logic          forceOn,
  input  logic [DW-1:0] startDelay,
  output logic [1:0]    state,
  output logic          xoscEn,
  output logic          soReadyN,
  output logic          soOe
);
  pwrState_t    curState;
  ctrlStrobes_t ctrl;
  logic         ready;

  xosc_power_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .csN          (csN),
    .strobeXoff   (strobeXoff),
    .strobePwrDown(strobePwrDown),
    .strobeReset  (strobeReset),
    .forceOn      (forceOn),
    .curState     (curState),
    .ctrl         (ctrl)
  );

  xosc_settle_dp #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .startDelay(startDelay),
    .ready     (ready)
  );

  assign state    = curState;
  assign xoscEn   = ctrl.oscEn;
  assign soReadyN = !ready;
  assign soOe     = !csN;
endmodule

// File: rtl/xosc_power_ctrl_chk.sv
module xosc_power_ctrl_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csN,
  input logic          strobeXoff,
  input logic          strobePwrDown,
  input logic          strobeReset,
  input logic          forceOn,
  input logic [DW-1:0] startDelay,
  input logic [1:0]    state,
  input logic          xoscEn,
  input logic          soReadyN,
  input logic          soOe
);
  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

  assert_idle_osc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> xoscEn);

  assert_not_ready_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xoscEn |-> soReadyN);

  assert_ignore_xoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && csN && !strobeReset) |=> (state == 2'd1));

  assert_ignore_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && csN && !strobeReset) |=> (state == 2'd2));

  assert_osc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && csN && !forceOn && !strobeReset) |=> !xoscEn);

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && !xoscEn && !csN && !strobeReset) |=> (state == 2'd0 && xoscEn));

  assert_force_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    forceOn |-> xoscEn);

  assert_reset_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobeReset |=> (state == 2'd0 && xoscEn));
endmodule

bind xosc_power_ctrl xosc_power_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/xosc_power_ctrl_tb.sv
module xosc_power_ctrl_tb;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1;
  logic strobeXoff = 1'b0, strobePwrDown = 1'b0, strobeReset = 1'b0;
  logic forceOn = 1'b0;
  logic [DW-1:0] startDelay = '0;
  logic [1:0] state;
  logic xoscEn, soReadyN, soOe;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xosc_power_ctrl #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .csN(csN),
    .strobeXoff(strobeXoff), .strobePwrDown(strobePwrDown), .strobeReset(strobeReset),
    .forceOn(forceOn), .startDelay(startDelay),
    .state(state), .xoscEn(xoscEn), .soReadyN(soReadyN), .soOe(soOe)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (d=%0d f=%0d)",
               tag, act, exp, startDelay, forceOn);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Ready check for k edges 0..d+1 after the oscillator is enabled.
  task automatic settleSweep(input int d, input string tag);
    for (int k = 0; k <= d + 1; k++) begin
      chk(soReadyN, (k < d) ? 1 : 0, tag);
      step(1);
    end
  endtask

  task automatic pulse(input logic x, input logic p, input logic r);
    strobeXoff = x; strobePwrDown = p; strobeReset = r;
    step(1);
    strobeXoff = 0; strobePwrDown = 0; strobeReset = 0;
  endtask

  initial begin
    for (int f = 0; f < 2; f++) begin
      for (int d = 0; d <= 5; d++) begin
        rst_n = 0; csN = 1; forceOn = f[0]; startDelay = d[DW-1:0];
        step(2);
        chk(state, 0, "R1 reset state");
        chk(xoscEn, 1, "R1 reset osc");
        chk(soOe, 0, "R9 deselected oe");
        rst_n = 1;
        settleSweep(d, "R1 R2 settle after reset");

        csN = 0;
        #0.5 chk(soOe, 1, "R9 selected oe");
        pulse(1, 0, 0);
        chk(state, 1, "R3 xoff strobe");
        chk(xoscEn, 1, "R5 osc on while selected");
        pulse(0, 1, 0);
        chk(state, 1, "R4 pwrdown ignored in XOFF");

        csN = 1;
        step(1);
        chk(xoscEn, f, "R5 R7 osc after deselect");
        chk(soReadyN, f ? 0 : 1, "R2 R7 ready after deselect");
        chk(state, 1, "R4 state held deselected");

        csN = 0;
        step(1);
        chk(state, 0, "R6 wake to IDLE");
        chk(xoscEn, 1, "R6 osc on at wake");
        if (f) chk(soReadyN, 0, "R7 ready kept across wake");
        else   settleSweep(d, "R6 R2 settle after wake");

        pulse(0, 1, 0);
        chk(state, 2, "R3 pwrdown strobe");
        csN = 1;
        step(1);
        chk(xoscEn, f, "R5 R7 osc in SLEEP");
        pulse(1, 0, 0);
        chk(state, 2, "R4 xoff ignored in SLEEP");
        pulse(0, 0, 1);
        chk(state, 0, "R8 reset from SLEEP");
        chk(xoscEn, 1, "R8 osc on after reset");
        settleSweep(d, "R8 R2 settle after reset strobe");

        csN = 0;
        pulse(1, 1, 0);
        chk(state, 1, "R3 xoff wins over pwrdown");
        pulse(1, 1, 1);
        chk(state, 0, "R8 reset priority");
        chk(xoscEn, 1, "R8 osc on");
        step(1);
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule